// File: doc/BRIEF.md
# Buffered Sparse Dot-Product Node

This block is a single processing node for a mesh that multiplies sparse matrices. Each cycle it can take one nonzero element from a row stream (side A) and one from a column stream (side B). An element is an index with a signed fixed-point value, and each stream presents its indices in ascending order. When the two indices are equal, the product of the two values goes into a signed accumulator. When they differ, the node never stalls either stream. Instead it parks the operand that is ahead, meaning the one with the larger index, in a small buffer on its own side. Each buffer entry has a valid flag. Every later operand is also looked up in the opposite side's buffer, so a match can be found after the two operands have arrived in different cycles.

The surrounding mesh pulses `sync` on the last cycle of every window of `DEPTH` element slots. That cycle's operands are still compared against both buffers. No new operand is parked on that cycle, and every flag is cleared at the following edge. A `start` cycle opens a new dot product: it clears the accumulator, both buffers and the end-of-vector tracking. Each stream marks its final element with a last flag. When both streams have delivered their last element, `done` pulses for one cycle and `result` holds the finished sum.

Top module: `sparse_dot_node`

## Requirements
- R1: When both inputs are valid, `start` is low and `a_idx == b_idx`, the product `a_val*b_val` is added to `result`, which is visible one cycle later.
- R2: A valid operand that matches neither the other input nor a buffered entry is parked in its own side's buffer. This happens when the other input is absent or has a smaller index, and only on a cycle without `sync`. Otherwise the operand is discarded and adds nothing later.
- R3: A valid operand that has no direct match but equals the index of a flagged entry in the opposite buffer adds its own value times the buffered value. That entry's flag is cleared, which frees the slot for a later park.
- R4: A direct match takes precedence over a buffer lookup. On such a cycle neither operand searches a buffer, and any buffered entry with the same index stays in place.
- R5: On a `sync` cycle the operands are compared and accumulated as usual, but nothing is parked, and every entry of both buffers is invalid after that edge.
- R6: `start` sets `result` to 0 and empties both buffers. It also forgets any last flags already seen. The operands presented on a `start` cycle are ignored.
- R7: A slot whose valid bit is low is absent: it causes no match, no park, no lookup, and its last flag is not counted.
- R8: `done` is high for exactly one cycle, in the cycle after the one in which the second of the two streams has presented a valid element with its last flag set. The last flag is counted once per stream after `start`. `result` then includes that cycle's products.
- R9: When a buffer already holds `DEPTH` flagged entries, an operand that would be parked there is dropped.
- R10: On a cycle with no direct match, the A operand and the B operand each search the opposite buffer independently. If both hit, both products are added in the same cycle.
- R11: `result` is two's complement with `2*VAL_W + clog2(MAX_LEN)` bits. Up to `MAX_LEN` products at the full-scale value (-2^(VAL_W-1))^2 sum exactly, without wrapping, whether positive or negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new dot product; clears accumulator, buffers and last tracking |
| sync | input | 1 | Last slot of a window; buffers are cleared after it |
| a_valid | input | 1 | Row-side element present |
| a_idx | input | IDX_W | Row-side element index |
| a_val | input | VAL_W | Row-side signed value |
| a_last | input | 1 | Row-side final element |
| b_valid | input | 1 | Column-side element present |
| b_idx | input | IDX_W | Column-side element index |
| b_val | input | VAL_W | Column-side signed value |
| b_last | input | 1 | Column-side final element |
| result | output | ACC_W | Signed accumulated dot product |
| done | output | 1 | One-cycle pulse when both streams have ended |

## Verification
The directed patterns separate the three ways a product can arise: two equal indices in the same cycle, an earlier A operand found later by B, and the reverse. One stimulus is built so that a direct match and a buffered entry carry the same index, which shows whether the direct pair wins and the entry survives. Other sequences park operands just before a `sync` or a `start`, or across a full buffer. They show that clearing and dropping really lose those operands, and that a freed slot can be reused. Randomized windows place the matching indices of the two streams at unrelated slots and leave some slots empty. Their outcome must equal the plain sparse dot product, and `done` must land in the cycle after whichever stream ends later.

// File: rtl/sdn_pkg.sv
package sdn_pkg;

  // Accumulator width: full signed product plus growth for max_len terms.
  function automatic int unsigned acc_bits(input int unsigned val_w, input int unsigned max_len);
    int unsigned lg;
    lg = 0;
    while ((32'd1 << lg) < max_len) lg++;
    return 2 * val_w + lg;
  endfunction

  // Entry count width able to hold 0..depth.
  function automatic int unsigned count_bits(input int unsigned depth);
    int unsigned lg;
    lg = 0;
    while ((32'd1 << lg) < depth + 1) lg++;
    return (lg == 0) ? 1 : lg;
  endfunction

endpackage

// File: rtl/sdn_cmp.sv
module sdn_cmp #(
  parameter int unsigned IDX_W = 8
) (
  input  logic             en,
  input  logic             a_v,
  input  logic [IDX_W-1:0] a_i,
  input  logic             b_v,
  input  logic [IDX_W-1:0] b_i,
  output logic             direct,
  output logic             a_ahead,
  output logic             b_ahead
);

  logic both;

  assign both    = a_v && b_v;
  assign direct  = en && both && (a_i == b_i);
  // An operand is "ahead" when the opposite side is absent or behind it.
  assign a_ahead = en && a_v && (!b_v || (a_i > b_i));
  assign b_ahead = en && b_v && (!a_v || (b_i > a_i));

endmodule

// File: rtl/sdn_opbuf.sv
module sdn_opbuf #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned VAL_W = 8,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CNT_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    look_en,
  input  logic [IDX_W-1:0]        look_idx,
  output logic                    hit,
  output logic signed [VAL_W-1:0] hit_val,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic signed [VAL_W-1:0] wr_val,
  output logic [CNT_W-1:0]        count
);

  logic [DEPTH-1:0]              flag_q;
  logic [IDX_W-1:0]              idx_q [DEPTH];
  logic signed [VAL_W-1:0]       val_q [DEPTH];
  logic [DEPTH-1:0]              match;
  logic [DEPTH-1:0]              wr_sel;

  // Per-entry match against the lookup operand.
  for (genvar e = 0; e < DEPTH; e++) begin : g_match
    assign match[e] = look_en && flag_q[e] && (idx_q[e] == look_idx);
  end

  // First matching entry supplies the buffered value.
  always_comb begin
    logic found;
    found   = 1'b0;
    hit_val = '0;
    for (int e = 0; e < DEPTH; e++) begin
      if (match[e] && !found) begin
        found   = 1'b1;
        hit_val = val_q[e];
      end
    end
    hit = found;
  end

  // Lowest free slot takes a parked operand.
  always_comb begin
    logic taken;
    taken  = 1'b0;
    wr_sel = '0;
    for (int e = 0; e < DEPTH; e++) begin
      if (!flag_q[e] && !taken) begin
        taken     = 1'b1;
        wr_sel[e] = wr_en;
      end
    end
  end

  always_comb begin
    count = '0;
    for (int e = 0; e < DEPTH; e++) begin
      count = count + CNT_W'(flag_q[e]);
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[e] <= 1'b0;
        idx_q[e]  <= '0;
        val_q[e]  <= '0;
      end else if (clr) begin
        flag_q[e] <= 1'b0;
      end else if (match[e]) begin
        flag_q[e] <= 1'b0;
      end else if (wr_sel[e]) begin
        flag_q[e] <= 1'b1;
        idx_q[e]  <= wr_idx;
        val_q[e]  <= wr_val;
      end
    end
  end

endmodule

// File: rtl/sdn_mac.sv
module sdn_mac #(
  parameter int unsigned VAL_W = 8,
  parameter int unsigned ACC_W = 22
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    t0_en,
  input  logic signed [VAL_W-1:0] t0_x,
  input  logic signed [VAL_W-1:0] t0_y,
  input  logic                    t1_en,
  input  logic signed [VAL_W-1:0] t1_x,
  input  logic signed [VAL_W-1:0] t1_y,
  output logic signed [ACC_W-1:0] acc
);

  // Signed product, widened to the accumulator before multiplying.
  function automatic logic signed [ACC_W-1:0] term(
    input logic en,
    input logic signed [VAL_W-1:0] x,
    input logic signed [VAL_W-1:0] y
  );
    logic signed [ACC_W-1:0] xe;
    logic signed [ACC_W-1:0] ye;
    xe = ACC_W'(x);
    ye = ACC_W'(y);
    return en ? (xe * ye) : '0;
  endfunction

  logic signed [ACC_W-1:0] sum_d;

  assign sum_d = acc + term(t0_en, t0_x, t0_y) + term(t1_en, t1_x, t1_y);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc <= '0;
    else if (clr) acc <= '0;
    else          acc <= sum_d;
  end

endmodule

// File: rtl/sparse_dot_node.sv
module sparse_dot_node #(
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned VAL_W   = 8,
  parameter int unsigned DEPTH   = 4,
  parameter int unsigned MAX_LEN = 64,
  localparam int unsigned ACC_W  = sdn_pkg::acc_bits(VAL_W, MAX_LEN),
  localparam int unsigned CNT_W  = sdn_pkg::count_bits(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    sync,
  input  logic                    a_valid,
  input  logic [IDX_W-1:0]        a_idx,
  input  logic signed [VAL_W-1:0] a_val,
  input  logic                    a_last,
  input  logic                    b_valid,
  input  logic [IDX_W-1:0]        b_idx,
  input  logic signed [VAL_W-1:0] b_val,
  input  logic                    b_last,
  output logic signed [ACC_W-1:0] result,
  output logic                    done
);

  logic                    op_en;
  logic                    direct;
  logic                    a_ahead;
  logic                    b_ahead;
  logic                    a_look;
  logic                    b_look;
  logic                    a_hit;
  logic                    b_hit;
  logic signed [VAL_W-1:0] a_partner;
  logic signed [VAL_W-1:0] b_partner;
  logic                    a_park;
  logic                    b_park;
  logic [CNT_W-1:0]        a_cnt;
  logic [CNT_W-1:0]        b_cnt;
  logic                    a_full;
  logic                    b_full;
  logic                    buf_clr;
  logic                    t0_en;
  logic signed [VAL_W-1:0] t0_y;

  assign op_en   = !start;
  assign buf_clr = start || sync;

  sdn_cmp #(.IDX_W(IDX_W)) u_cmp (
    .en      (op_en),
    .a_v     (a_valid),
    .a_i     (a_idx),
    .b_v     (b_valid),
    .b_i     (b_idx),
    .direct  (direct),
    .a_ahead (a_ahead),
    .b_ahead (b_ahead)
  );

  // Buffer lookups only when the incoming pair did not match directly.
  assign a_look = op_en && a_valid && !direct;
  assign b_look = op_en && b_valid && !direct;

  assign a_full = (a_cnt == CNT_W'(DEPTH));
  assign b_full = (b_cnt == CNT_W'(DEPTH));

  assign a_park = a_ahead && !a_hit && !sync && !a_full;
  assign b_park = b_ahead && !b_hit && !sync && !b_full;

  // Side A buffer: holds parked A operands, searched by the B operand.
  sdn_opbuf #(.IDX_W(IDX_W), .VAL_W(VAL_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_abuf (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (buf_clr),
    .look_en  (b_look),
    .look_idx (b_idx),
    .hit      (b_hit),
    .hit_val  (b_partner),
    .wr_en    (a_park),
    .wr_idx   (a_idx),
    .wr_val   (a_val),
    .count    (a_cnt)
  );

  // Side B buffer: holds parked B operands, searched by the A operand.
  sdn_opbuf #(.IDX_W(IDX_W), .VAL_W(VAL_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_bbuf (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (buf_clr),
    .look_en  (a_look),
    .look_idx (a_idx),
    .hit      (a_hit),
    .hit_val  (a_partner),
    .wr_en    (b_park),
    .wr_idx   (b_idx),
    .wr_val   (b_val),
    .count    (b_cnt)
  );

  assign t0_en = direct || a_hit;
  assign t0_y  = direct ? b_val : a_partner;

  sdn_mac #(.VAL_W(VAL_W), .ACC_W(ACC_W)) u_mac (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start),
    .t0_en (t0_en),
    .t0_x  (a_val),
    .t0_y  (t0_y),
    .t1_en (b_hit),
    .t1_x  (b_val),
    .t1_y  (b_partner),
    .acc   (result)
  );

  // End-of-vector tracking and completion strobe.
  logic seen_a_q;
  logic seen_b_q;
  logic seen_a_d;
  logic seen_b_d;

  assign seen_a_d = seen_a_q || (op_en && a_valid && a_last);
  assign seen_b_d = seen_b_q || (op_en && b_valid && b_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_a_q <= 1'b0;
      seen_b_q <= 1'b0;
      done     <= 1'b0;
    end else if (start) begin
      seen_a_q <= 1'b0;
      seen_b_q <= 1'b0;
      done     <= 1'b0;
    end else begin
      seen_a_q <= seen_a_d;
      seen_b_q <= seen_b_d;
      done     <= seen_a_d && seen_b_d && !(seen_a_q && seen_b_q);
    end
  end

endmodule

// File: rtl/sdn_checker.sv
module sdn_checker #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned VAL_W = 8,
  parameter int unsigned ACC_W = 22,
  parameter int unsigned CNT_W = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic                    sync,
  input logic                    a_valid,
  input logic [IDX_W-1:0]        a_idx,
  input logic signed [VAL_W-1:0] a_val,
  input logic                    b_valid,
  input logic [IDX_W-1:0]        b_idx,
  input logic signed [VAL_W-1:0] b_val,
  input logic signed [ACC_W-1:0] result,
  input logic                    done,
  input logic                    direct,
  input logic                    a_park,
  input logic                    b_park,
  input logic [CNT_W-1:0]        a_cnt,
  input logic [CNT_W-1:0]        b_cnt
);

  logic signed [ACC_W-1:0] pair_prod;
  assign pair_prod = ACC_W'(a_val) * ACC_W'(b_val);

  a_r1_direct_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && a_valid && b_valid && (a_idx == b_idx)) |=> (result == $past(result) + $past(pair_prod)));

  a_r4_direct_no_park: assert property (@(posedge clk) disable iff (!rst_n)
    direct |-> (!a_park && !b_park));

  a_r5_sync_empties: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> (a_cnt == '0 && b_cnt == '0));

  a_r6_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (result == '0 && a_cnt == '0 && b_cnt == '0 && !done));

  a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !sync && !a_valid && !b_valid) |=>
      (result == $past(result) && a_cnt == $past(a_cnt) && b_cnt == $past(b_cnt)));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r2_no_park_on_sync: assert property (@(posedge clk) disable iff (!rst_n)
    sync |-> (!a_park && !b_park));

endmodule

bind sparse_dot_node sdn_checker #(
  .IDX_W(IDX_W), .VAL_W(VAL_W), .ACC_W(ACC_W), .CNT_W(CNT_W)
) u_sdn_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .sync    (sync),
  .a_valid (a_valid),
  .a_idx   (a_idx),
  .a_val   (a_val),
  .b_valid (b_valid),
  .b_idx   (b_idx),
  .b_val   (b_val),
  .result  (result),
  .done    (done),
  .direct  (direct),
  .a_park  (a_park),
  .b_park  (b_park),
  .a_cnt   (a_cnt),
  .b_cnt   (b_cnt)
);

// File: tb/tb_sparse_dot_node.sv
module tb_sparse_dot_node;

  localparam int IDX_W   = 8;
  localparam int VAL_W   = 8;
  localparam int DEPTH   = 4;
  localparam int MAX_LEN = 64;
  localparam int ACC_W   = 22;
  localparam int NW      = 8;
  localparam int SLOTS   = NW * DEPTH;

  logic clk = 1'b0;
  logic rst_n;
  logic start, sync;
  logic a_valid, a_last, b_valid, b_last;
  logic [IDX_W-1:0] a_idx, b_idx;
  logic signed [VAL_W-1:0] a_val, b_val;
  logic signed [ACC_W-1:0] result;
  logic done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sparse_dot_node #(.IDX_W(IDX_W), .VAL_W(VAL_W), .DEPTH(DEPTH), .MAX_LEN(MAX_LEN)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sync(sync),
    .a_valid(a_valid), .a_idx(a_idx), .a_val(a_val), .a_last(a_last),
    .b_valid(b_valid), .b_idx(b_idx), .b_val(b_val), .b_last(b_last),
    .result(result), .done(done)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle_in();
    start = 0; sync = 0;
    a_valid = 0; a_idx = '0; a_val = '0; a_last = 0;
    b_valid = 0; b_idx = '0; b_val = '0; b_last = 0;
  endtask

  task automatic put_a(input int i, input int v, input bit l = 0);
    a_valid = 1; a_idx = IDX_W'(i); a_val = VAL_W'(v); a_last = l;
  endtask

  task automatic put_b(input int i, input int v, input bit l = 0);
    b_valid = 1; b_idx = IDX_W'(i); b_val = VAL_W'(v); b_last = l;
  endtask

  // Apply the prepared inputs for one edge, then sample at the next falling edge.
  task automatic step();
    @(negedge clk);
    idle_in();
  endtask

  task automatic begin_dot();
    start = 1;
    step();
  endtask

  function automatic longint res();
    return longint'(result);
  endfunction

  // Random stream storage
  bit av_s[SLOTS];  int ai_s[SLOTS];  int avl_s[SLOTS];
  bit bv_s[SLOTS];  int bi_s[SLOTS];  int bvl_s[SLOTS];

  function automatic longint ref_dot();
    longint s = 0;
    for (int x = 0; x < SLOTS; x++)
      for (int y = 0; y < SLOTS; y++)
        if (av_s[x] && bv_s[y] && ai_s[x] == bi_s[y]) s += longint'(avl_s[x]) * longint'(bvl_s[y]);
    return s;
  endfunction

  // Fill one side: each window uses its own block of 16 indices, ascending, gaps random.
  task automatic gen_side(output bit v[SLOTS], output int ix[SLOTS], output int vl[SLOTS]);
    for (int w = 0; w < NW; w++) begin
      int pick[DEPTH];
      int k = 0;
      int rem;
      for (int x = 0; x < 16; x++) begin
        bool_pick: begin
          bit fin = (w == NW - 1) && (x == 15);
          bit take = ((w != NW - 1) || (x != 15)) && (k < ((w == NW - 1) ? DEPTH - 1 : DEPTH))
                     && (($urandom % 3) == 0);
          if (fin || take) begin pick[k] = w * 16 + x; k++; end
        end
      end
      rem = 0;
      for (int s = 0; s < DEPTH; s++) begin
        int slot = w * DEPTH + s;
        bit use_it = (rem < k) && (((k - rem) == (DEPTH - s)) || (($urandom % 3) != 0));
        v[slot]  = use_it;
        ix[slot] = use_it ? pick[rem] : 0;
        vl[slot] = $signed(VAL_W'($urandom));
        if (use_it) rem++;
      end
    end
  endtask

  task automatic run_random(input int n);
    int la = 0, lb = 0, tdone;
    longint exp;
    int bad_done = 0;
    gen_side(av_s, ai_s, avl_s);
    gen_side(bv_s, bi_s, bvl_s);
    for (int t = 0; t < SLOTS; t++) begin
      if (av_s[t]) la = t;
      if (bv_s[t]) lb = t;
    end
    tdone = (la > lb) ? la : lb;
    exp = ref_dot();
    begin_dot();
    for (int t = 0; t < SLOTS; t++) begin
      if (av_s[t]) put_a(ai_s[t], avl_s[t], t == la);
      if (bv_s[t]) put_b(bi_s[t], bvl_s[t], t == lb);
      sync = ((t % DEPTH) == DEPTH - 1);
      step();
      if (done != (t == tdone)) bad_done++;
      if (t == tdone) chk($sformatf("R3 R2 R10 random run %0d dot product", n), res(), exp);
    end
    chk($sformatf("R8 random run %0d done timing mismatches", n), bad_done, 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idle_in();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("reset result", res(), 0);
    chk("reset done", done, 0);

    // R1: direct matches accumulate
    begin_dot();
    put_a(3, 5); put_b(3, -7); step();
    chk("R1 direct product", res(), -35);
    put_a(8, -2); put_b(8, -3); step();
    chk("R1 second direct product", res(), -29);

    // R2, R3: parking and later lookup in both directions
    begin_dot();
    put_a(5, 6); put_b(1, 2); step();
    chk("R2 mismatch adds nothing", res(), 0);
    put_b(3, 4); step();
    put_b(5, -3); step();
    chk("R3 B finds parked A", res(), -18);
    put_a(3, 10); step();
    chk("R3 A finds parked B", res(), 22);
    put_a(1, 7); step();
    chk("R2 smaller operand was discarded", res(), 22);

    // R4: direct match wins, buffered entry stays
    begin_dot();
    put_a(7, 3); step();
    put_a(7, 5); put_b(7, 2); step();
    chk("R4 direct pair used", res(), 10);
    put_b(7, 4); step();
    chk("R4 buffered entry still present", res(), 22);

    // R5: sync cycle still compares, then buffers are empty
    begin_dot();
    put_a(9, 3); step();
    put_a(11, 1); step();
    put_a(12, 2); put_b(9, 5); sync = 1; step();
    chk("R5 compare on sync cycle", res(), 15);
    put_b(11, 4); step();
    put_b(12, 4); step();
    chk("R5 entries gone after sync", res(), 15);

    // R6: operands on start cycle ignored
    put_a(4, 5, 1); put_b(4, 5, 1); start = 1; step();
    chk("R6 start clears result", res(), 0);
    chk("R6 start cycle last ignored", done, 0);
    put_b(4, 1); step();
    chk("R6 nothing parked on start", res(), 0);

    // R7: invalid slot is absent
    begin_dot();
    a_idx = 6; a_val = 9; a_last = 1; put_b(6, 2); step();
    chk("R7 invalid A no direct", res(), 0);
    chk("R7 invalid last not counted", done, 0);
    put_a(6, 3); step();
    chk("R7 B parked while A absent", res(), 6);

    // R9 and R3 slot reuse
    begin_dot();
    for (int k = 0; k < 5; k++) begin put_a(k + 1, 1 << k); step(); end
    for (int k = 0; k < 5; k++) begin put_b(k + 1, 1); step(); end
    chk("R9 fifth operand dropped on full buffer", res(), 15);
    for (int k = 0; k < 4; k++) begin put_a(10 + k, 1); step(); end
    put_b(13, 100); step();
    chk("R3 freed slots reused", res(), 115);

    // R10: two hits in one cycle
    begin_dot();
    put_a(4, 3); step();
    put_b(6, 5); step();
    put_a(6, 2); put_b(4, 7); step();
    chk("R10 both sides hit", res(), 31);

    // R8: done strobe
    begin_dot();
    put_a(1, 2, 1); step();
    chk("R8 no done after one stream", done, 0);
    put_b(2, 3); step();
    put_b(1, 4, 1); step();
    chk("R8 done after second last", done, 1);
    chk("R8 result at done", res(), 8);
    step();
    chk("R8 done lasts one cycle", done, 0);
    chk("R8 result holds", res(), 8);

    // R11: full-scale sums
    begin_dot();
    for (int k = 0; k < MAX_LEN; k++) begin put_a(k, -128); put_b(k, -128); step(); end
    chk("R11 positive full scale", res(), 1048576);
    begin_dot();
    for (int k = 0; k < MAX_LEN; k++) begin put_a(k, -128); put_b(k, 127); step(); end
    chk("R11 negative full scale", res(), -1040384);

    for (int n = 0; n < 6; n++) run_random(n);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule